// File: doc/BRIEF.md
# Cache Frame Directory with Background Eviction

This block keeps the bookkeeping for a page-granular, tagless in-package DRAM cache. It holds one entry per cache frame and addresses it directly by frame number, so nothing is ever searched associatively. Each entry records the main-memory page frame backing it, the address of the page table entry that currently points at the cache frame, a bit per core that says whether that core's translation buffer holds the mapping, a dirty flag and a life-cycle state.

Unused frames are chained into a singly linked free list. A page walker asks for a frame through a valid/ready allocation port and gets the head of the list at once. When free frames plus frames already on their way out fall below a low-water mark, a scanner walks the frames round-robin, one per cycle. It picks frames that are in use but mapped by no core and puts them in a short eviction queue. A background engine drains that queue. It writes a dirty page back to memory, then rewrites the owning page table entry so it points at main memory again with its in-cache flag cleared, and only then links the frame onto the tail of the free list. Page data movement is abstracted as one request on the memory port plus an acknowledge.

Back-pressure: an allocation completes on a cycle where `alloc_valid` and `alloc_ready` are both high, and `alloc_ready` is low exactly when no frame is free. On the memory port the block raises `mem_req_valid` and holds it, with every request field unchanged, until it sees `mem_req_ready`. It then waits for a one-cycle `mem_ack` before it issues anything else.

Top module: `frame_directory`

## Requirements
- R1: After reset all 64 frames are free, `free_count` is 64 and successive allocations return frames 0, 1, 2, … in index order.
- R2: An accepted allocation returns the current free-list head on `alloc_frame`, lowers `free_count` by one on the next cycle, and records the given page frame and entry address with only the requesting core's residence bit set and the dirty flag clear.
- R3: A residence event sets (`res_set`=1) or clears (`res_set`=0) one core's bit of one frame; a frame with any bit set is never chosen for eviction.
- R4: A frame is chosen for eviction only while free frames plus frames in eviction number fewer than 8, and only if it is in use with an all-zero residence vector; the scanner looks at one frame per cycle, round-robin.
- R5: Chosen frames wait in an eviction queue of 4 entries that is never pushed while full.
- R6: For a dirty frame the engine first issues a page writeback (`mem_req_page`=1) carrying the cache frame and its backing page frame, then the entry update; a clean frame gets the entry update only.
- R7: The entry update (`mem_req_page`=0) carries the owning entry's address and the backing page frame that replaces the cache address, with the in-cache flag to be cleared.
- R8: A frame rejoins the free list, at its tail, only after the acknowledge of its last memory request; `free_count` then rises by one, and later allocations return freed frames in the order they were freed.
- R9: A memory request stays valid with stable fields until accepted, and at most one is outstanding until its acknowledge.
- R10: `alloc_ready` is low when `free_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A free frame is available |
| alloc_core | input | 2 | Core whose translation buffer will map the frame |
| alloc_pfn | input | 20 | Backing main-memory page frame |
| alloc_pte_addr | input | 32 | Address of the owning page table entry |
| alloc_frame | output | 6 | Frame granted (free-list head) |
| res_valid | input | 1 | Residence event strobe |
| res_set | input | 1 | 1 sets, 0 clears the bit |
| res_core | input | 2 | Core of the event |
| res_frame | input | 6 | Frame of the event |
| dirty_valid | input | 1 | Mark a frame dirty |
| dirty_frame | input | 6 | Frame to mark |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory side accepts the request |
| mem_req_page | output | 1 | 1 = page writeback, 0 = entry update |
| mem_req_frame | output | 6 | Cache frame concerned |
| mem_req_pfn | output | 20 | Backing page frame |
| mem_req_pte_addr | output | 32 | Owning entry address |
| mem_ack | input | 1 | Completion of the accepted request |
| free_count | output | 7 | Number of frames on the free list |

## Verification
Every cycle the assertions check several things. Allocation only ever hands out a frame in the free state, and never pops an empty list. Victims are always in use, unmapped and taken below the low-water mark, and the eviction queue is never overrun. A stalled memory request keeps its fields, and a frame is released only after an acknowledge. Only the bench scenarios can show the end-to-end orderings: frames come out in index order after reset, and a dirty frame gets a writeback before its entry update. The low-water mark stops eviction at exactly eight free frames, a frame kept alive by a second core's bit survives until that bit clears, and freed frames come back in release order.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic [1:0] {
    FS_FREE = 2'd0,
    FS_LIVE = 2'd1,
    FS_GONE = 2'd2
  } frame_state_e;

  typedef enum logic [2:0] {
    E_IDLE,
    E_PAGE_REQ,
    E_PAGE_WAIT,
    E_PTE_REQ,
    E_PTE_WAIT,
    E_DONE
  } evict_state_e;
endpackage

// File: rtl/fd_free_list.sv
module fd_free_list #(
  parameter int NFRAMES = 64,
  localparam int FW = $clog2(NFRAMES),
  localparam int CW = $clog2(NFRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [FW-1:0] push_frame,
  output logic [FW-1:0] head,
  output logic [CW-1:0] count
);
  logic [FW-1:0] link_q [NFRAMES];
  logic [FW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFRAMES; i++) link_q[i] <= FW'(i + 1);
      head_q <= '0;
      tail_q <= FW'(NFRAMES - 1);
      cnt_q  <= CW'(NFRAMES);
    end else begin
      if (push) begin
        link_q[tail_q] <= push_frame;
        tail_q         <= push_frame;
      end
      if (push && (cnt_q == '0 || (pop && cnt_q == CW'(1))))
        head_q <= push_frame;
      else if (pop)
        head_q <= link_q[head_q];
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head  = head_q;
  assign count = cnt_q;

  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NFRAMES));
endmodule

// File: rtl/fd_evict_fifo.sv
module fd_evict_fifo #(
  parameter int DEPTH = 4,
  parameter int W = 6,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [NW-1:0] n_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
      n_q  <= '0;
    end else begin
      if (push) begin
        slot_q[wr_q] <= din;
        wr_q         <= bump(wr_q);
      end
      if (pop) rd_q <= bump(rd_q);
      n_q <= n_q + NW'(push) - NW'(pop);
    end
  end

  assign dout  = slot_q[rd_q];
  assign empty = (n_q == '0);
  assign full  = (n_q == NW'(DEPTH));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/fd_victim_scan.sv
module fd_victim_scan #(
  parameter int NFRAMES = 64,
  localparam int FW = $clog2(NFRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cand_live,
  input  logic          cand_unmapped,
  input  logic          cand_blocked,
  input  logic          q_full,
  output logic [FW-1:0] ptr,
  output logic          pick
);
  logic [FW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (enable)
      ptr_q <= (ptr_q == FW'(NFRAMES - 1)) ? '0 : ptr_q + FW'(1);
  end

  assign ptr  = ptr_q;
  assign pick = enable && cand_live && cand_unmapped && !cand_blocked && !q_full;
endmodule

// File: rtl/fd_evict_engine.sv
module fd_evict_engine
  import fd_pkg::*;
#(
  parameter int FW = 6,
  parameter int PFN_W = 20,
  parameter int PTEA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [FW-1:0]     q_frame,
  input  logic [PFN_W-1:0]  ent_pfn,
  input  logic [PTEA_W-1:0] ent_pte_addr,
  input  logic              ent_dirty,
  output logic              q_pop,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_page,
  output logic [FW-1:0]     mem_frame,
  output logic [PFN_W-1:0]  mem_pfn,
  output logic [PTEA_W-1:0] mem_pte_addr,
  input  logic              mem_ack,
  output logic              rel_valid,
  output logic [FW-1:0]     rel_frame
);
  evict_state_e st_q, st_d;
  logic [FW-1:0]     frame_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [PTEA_W-1:0] ptea_q;

  always_comb begin
    st_d  = st_q;
    q_pop = 1'b0;
    unique case (st_q)
      E_IDLE: if (!q_empty) begin
        q_pop = 1'b1;
        st_d  = ent_dirty ? E_PAGE_REQ : E_PTE_REQ;
      end
      E_PAGE_REQ:  if (mem_ready) st_d = E_PAGE_WAIT;
      E_PAGE_WAIT: if (mem_ack)   st_d = E_PTE_REQ;
      E_PTE_REQ:   if (mem_ready) st_d = E_PTE_WAIT;
      E_PTE_WAIT:  if (mem_ack)   st_d = E_DONE;
      E_DONE:      st_d = E_IDLE;
      default:     st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      frame_q <= '0;
      pfn_q   <= '0;
      ptea_q  <= '0;
    end else begin
      st_q <= st_d;
      if (q_pop) begin
        frame_q <= q_frame;
        pfn_q   <= ent_pfn;
        ptea_q  <= ent_pte_addr;
      end
    end
  end

  assign mem_valid    = (st_q == E_PAGE_REQ) || (st_q == E_PTE_REQ);
  assign mem_page     = (st_q == E_PAGE_REQ);
  assign mem_frame    = frame_q;
  assign mem_pfn      = pfn_q;
  assign mem_pte_addr = ptea_q;
  assign rel_valid    = (st_q == E_DONE);
  assign rel_frame    = frame_q;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_frame) && $stable(mem_page)
      && $stable(mem_pfn) && $stable(mem_pte_addr));
  assert_release_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> $past(mem_ack));
  assert_page_before_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) && !mem_page |-> $past(q_pop) || $past(mem_ack));
endmodule

// File: rtl/frame_directory.sv
module frame_directory
  import fd_pkg::*;
#(
  parameter int NFRAMES = 64,
  parameter int NCORES = 4,
  parameter int ALPHA = 8,
  parameter int QDEPTH = 4,
  parameter int PFN_W = 20,
  parameter int PTEA_W = 32,
  localparam int FW = $clog2(NFRAMES),
  localparam int CW = $clog2(NFRAMES + 1),
  localparam int KW = $clog2(NCORES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [KW-1:0]     alloc_core,
  input  logic [PFN_W-1:0]  alloc_pfn,
  input  logic [PTEA_W-1:0] alloc_pte_addr,
  output logic [FW-1:0]     alloc_frame,
  input  logic              res_valid,
  input  logic              res_set,
  input  logic [KW-1:0]     res_core,
  input  logic [FW-1:0]     res_frame,
  input  logic              dirty_valid,
  input  logic [FW-1:0]     dirty_frame,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_page,
  output logic [FW-1:0]     mem_req_frame,
  output logic [PFN_W-1:0]  mem_req_pfn,
  output logic [PTEA_W-1:0] mem_req_pte_addr,
  input  logic              mem_ack,
  output logic [CW-1:0]     free_count
);
  frame_state_e      state_q [NFRAMES];
  logic [NCORES-1:0] resid_q [NFRAMES];
  logic [PFN_W-1:0]  pfn_q   [NFRAMES];
  logic [PTEA_W-1:0] ptea_q  [NFRAMES];
  logic              dirty_q [NFRAMES];

  logic [FW-1:0] head, scan_ptr, q_frame, rel_frame;
  logic          alloc_fire, scan_pick, scan_en, q_empty, q_full, q_pop, rel_valid;
  logic [CW-1:0] inflight_q;
  logic [CW:0]   pressure;

  assign alloc_ready = (free_count != '0);
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_frame = head;
  assign pressure    = {1'b0, free_count} + {1'b0, inflight_q};
  assign scan_en     = pressure < (CW + 1)'(ALPHA);

  fd_free_list #(.NFRAMES(NFRAMES)) u_free (
    .clk(clk), .rst_n(rst_n), .pop(alloc_fire), .push(rel_valid),
    .push_frame(rel_frame), .head(head), .count(free_count));

  fd_victim_scan #(.NFRAMES(NFRAMES)) u_scan (
    .clk(clk), .rst_n(rst_n), .enable(scan_en),
    .cand_live(state_q[scan_ptr] == FS_LIVE),
    .cand_unmapped(resid_q[scan_ptr] == '0),
    .cand_blocked(res_valid && res_set && res_frame == scan_ptr),
    .q_full(q_full), .ptr(scan_ptr), .pick(scan_pick));

  fd_evict_fifo #(.DEPTH(QDEPTH), .W(FW)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(scan_pick), .din(scan_ptr),
    .pop(q_pop), .dout(q_frame), .empty(q_empty), .full(q_full));

  fd_evict_engine #(.FW(FW), .PFN_W(PFN_W), .PTEA_W(PTEA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_frame(q_frame),
    .ent_pfn(pfn_q[q_frame]), .ent_pte_addr(ptea_q[q_frame]),
    .ent_dirty(dirty_q[q_frame]), .q_pop(q_pop),
    .mem_valid(mem_req_valid), .mem_ready(mem_req_ready), .mem_page(mem_req_page),
    .mem_frame(mem_req_frame), .mem_pfn(mem_req_pfn), .mem_pte_addr(mem_req_pte_addr),
    .mem_ack(mem_ack), .rel_valid(rel_valid), .rel_frame(rel_frame));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFRAMES; i++) begin
        state_q[i] <= FS_FREE;
        resid_q[i] <= '0;
        pfn_q[i]   <= '0;
        ptea_q[i]  <= '0;
        dirty_q[i] <= 1'b0;
      end
      inflight_q <= '0;
    end else begin
      if (alloc_fire) begin
        state_q[head] <= FS_LIVE;
        resid_q[head] <= NCORES'(1) << alloc_core;
        pfn_q[head]   <= alloc_pfn;
        ptea_q[head]  <= alloc_pte_addr;
        dirty_q[head] <= 1'b0;
      end
      if (res_valid) resid_q[res_frame][res_core] <= res_set;
      if (dirty_valid) dirty_q[dirty_frame] <= 1'b1;
      if (scan_pick) state_q[scan_ptr] <= FS_GONE;
      if (rel_valid) begin
        state_q[rel_frame] <= FS_FREE;
        dirty_q[rel_frame] <= 1'b0;
      end
      inflight_q <= inflight_q + CW'(scan_pick) - CW'(rel_valid);
    end
  end

  assert_alloc_free_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> state_q[head] == FS_FREE);
  assert_victim_unmapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_pick |-> resid_q[scan_ptr] == '0 && state_q[scan_ptr] == FS_LIVE);
  assert_low_water_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_pick |-> pressure < (CW + 1)'(ALPHA));
  assert_release_evicting_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> state_q[rel_frame] == FS_GONE);
endmodule

// File: tb/test_frame_directory.sv
module test_frame_directory;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0, alloc_ready;
  logic [1:0]  alloc_core = '0;
  logic [19:0] alloc_pfn = '0;
  logic [31:0] alloc_pte_addr = '0;
  logic [5:0]  alloc_frame;
  logic        res_valid = 1'b0, res_set = 1'b0;
  logic [1:0]  res_core = '0;
  logic [5:0]  res_frame = '0;
  logic        dirty_valid = 1'b0;
  logic [5:0]  dirty_frame = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_req_page, mem_ack = 1'b0;
  logic [5:0]  mem_req_frame;
  logic [19:0] mem_req_pfn;
  logic [31:0] mem_req_pte_addr;
  logic [6:0]  free_count;

  int n_vec = 0, n_bad = 0;
  int released[16];
  int n_rel = 0;
  bit done = 1'b0;

  frame_directory i_frame_directory (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_core(alloc_core), .alloc_pfn(alloc_pfn), .alloc_pte_addr(alloc_pte_addr),
    .alloc_frame(alloc_frame), .res_valid(res_valid), .res_set(res_set),
    .res_core(res_core), .res_frame(res_frame), .dirty_valid(dirty_valid),
    .dirty_frame(dirty_frame), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_page(mem_req_page),
    .mem_req_frame(mem_req_frame), .mem_req_pfn(mem_req_pfn),
    .mem_req_pte_addr(mem_req_pte_addr), .mem_ack(mem_ack), .free_count(free_count));

  always #10 clk = ~clk;

  function automatic int exp_pfn(int f);  return 100 + 3 * f; endfunction
  function automatic int exp_ptea(int f); return 32'h1000 + 8 * f; endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_alloc(int exp_frame, int core, int pfn, int ptea, string tag);
    alloc_valid = 1'b1; alloc_core = 2'(core);
    alloc_pfn = 20'(pfn); alloc_pte_addr = 32'(ptea);
    #1;
    chk({tag, " ready"}, int'(alloc_ready), 1);
    chk({tag, " frame"}, int'(alloc_frame), exp_frame);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic res_event(int f, int core, bit set);
    res_valid = 1'b1; res_frame = 6'(f); res_core = 2'(core); res_set = set;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic quiet(int n, string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (mem_req_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(tag, int'(seen), 0);
  endtask

  task automatic wait_req(output bit ok);
    int w = 0;
    while (!mem_req_valid && w < 3000) begin @(negedge clk); w++; end
    ok = mem_req_valid;
  endtask

  task automatic accept_req(int f, int page);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9 request held while stalled", int'(mem_req_valid), 1);
      chk("R9 frame stable while stalled", int'(mem_req_frame), f);
      chk("R9 kind stable while stalled", int'(mem_req_page), page);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 nothing issued before ack", int'(mem_req_valid), 0);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
  endtask

  task automatic evict_job(output int f);
    bit ok, dty;
    f = -1;
    wait_req(ok);
    if (!ok) begin
      chk("R4 eviction request expected", 0, 1);
      return;
    end
    f = int'(mem_req_frame);
    dty = (f % 3 == 0);
    chk("R6 first request kind", int'(mem_req_page), int'(dty));
    if (dty) begin
      chk("R6 writeback page frame", int'(mem_req_pfn), exp_pfn(f));
      accept_req(f, 1);
      wait_req(ok);
      chk("R6 entry update follows writeback", int'(ok), 1);
      chk("R6 entry update kind", int'(mem_req_page), 0);
      chk("R6 entry update frame", int'(mem_req_frame), f);
    end
    chk("R7 entry address", int'(mem_req_pte_addr), exp_ptea(f));
    chk("R7 restored page frame", int'(mem_req_pfn), exp_pfn(f));
    accept_req(f, 0);
    released[n_rel] = f;
    n_rel++;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int f;
    bit [63:0] seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 free count after reset", int'(free_count), 64);
    chk("R1 ready after reset", int'(alloc_ready), 1);
    chk("R1 head after reset", int'(alloc_frame), 0);
    chk("R9 idle memory port", int'(mem_req_valid), 0);

    // R1/R2: fill every frame, index order, count steps down
    for (int i = 0; i < 64; i++) begin
      do_alloc(i, i % 4, exp_pfn(i), exp_ptea(i), "R1 index order alloc");
      chk("R2 count after alloc", int'(free_count), 63 - i);
    end
    chk("R10 ready low when empty", int'(alloc_ready), 0);

    for (int i = 0; i < 64; i += 3) begin
      dirty_valid = 1'b1; dirty_frame = 6'(i);
      @(negedge clk);
    end
    dirty_valid = 1'b0;

    // R3: frame 40 moves from core 0 to core 1, still mapped
    res_event(40, 1, 1'b1);
    res_event(40, 0, 1'b0);
    quiet(150, "R3 R4 no victim while every frame is mapped");

    // R4/R7 clean single eviction
    res_event(10, 2, 1'b0);
    evict_job(f);
    chk("R4 victim is the unmapped frame", f, 10);
    repeat (3) @(negedge clk);
    chk("R8 count after first release", int'(free_count), 1);

    // R6 dirty single eviction
    res_event(12, 0, 1'b0);
    evict_job(f);
    chk("R4 victim is the unmapped frame", f, 12);
    repeat (3) @(negedge clk);
    chk("R8 count after second release", int'(free_count), 2);

    // R5: six victims at once, queue fills behind a stalled engine
    for (int i = 20; i < 26; i++) res_event(i, i % 4, 1'b0);
    seen = '0;
    for (int k = 0; k < 6; k++) begin
      evict_job(f);
      chk("R5 victim in group", int'(f >= 20 && f < 26), 1);
      if (f >= 0) begin
        chk("R5 victim evicted once", int'(seen[f]), 0);
        seen[f] = 1'b1;
      end
    end
    repeat (3) @(negedge clk);
    chk("R8 count after group", int'(free_count), 8);

    // R4 threshold: eight free frames stop eviction
    res_event(30, 2, 1'b0);
    quiet(200, "R4 no eviction at eight free frames");
    do_alloc(10, 0, exp_pfn(10), exp_ptea(10), "R8 first freed frame reused");
    repeat (2) @(negedge clk);
    chk("R2 count after realloc", int'(free_count), 7);
    evict_job(f);
    chk("R4 eviction resumes below mark", f, 30);
    repeat (3) @(negedge clk);
    chk("R8 count after frame 30", int'(free_count), 8);

    // R3: clearing the second core's bit releases frame 40
    res_event(40, 1, 1'b0);
    do_alloc(12, 0, exp_pfn(12), exp_ptea(12), "R8 second freed frame reused");
    evict_job(f);
    chk("R3 frame 40 evicted once unmapped", f, 40);
    repeat (3) @(negedge clk);
    chk("R8 count after frame 40", int'(free_count), 8);

    // R8: drain the list in release order
    for (int k = 2; k < n_rel; k++)
      do_alloc(released[k], 1, exp_pfn(released[k]), exp_ptea(released[k]),
               "R8 release order");
    chk("R10 ready low after drain", int'(alloc_ready), 0);
    chk("R10 count zero after drain", int'(free_count), 0);
    quiet(100, "R3 reallocated frames stay resident");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule